// File: doc/BRIEF.md
# Logical-to-Physical Map with Stored-Address Tag Check

This block holds the translation from each host logical block address (LBA) to the flash page that carries its data. Every entry holds a page pointer, a mapped flag and one even-parity bit. A write request records the page for its LBA. The same request returns the storage word: the LBA placed in the upper bits and the user data in the lower bits, so that both travel into the page together. A read request looks the LBA up in the table and returns the page, or a status that says the entry is unmapped or that its parity is bad.

The data path then fetches the page and presents the LBA tag found in it. The block compares that tag with the LBA of the last good lookup and reports the result one cycle later. Parity failures and tag mismatches each set their own sticky error flag. The flags hold until a clear pulse. Requests use a valid/ready handshake, and each accepted request produces exactly one response on the following cycle.

Host sectors are 512 bytes and flash pages are 4 KB or 8 KB, so the pointer width and table depth are parameters. The defaults are a 1024-entry table with 16-bit page pointers.

Top module: `l2p_tag_map`

## Requirements
- R1: After reset, rsp_valid, chk_valid, err_parity and err_tag are 0, req_ready is 1, and every LBA reads back as unmapped.
- R2: An accepted write produces, on the next cycle, a response with rsp_write=1, rsp_status=2'b00, rsp_page equal to the written page, and rsp_word = {lba, data}, with the LBA in the upper LBA_W bits.
- R3: An accepted read of a mapped LBA produces, on the next cycle, rsp_status=2'b00 and the page from the most recent write to that LBA.
- R4: A read of an unmapped LBA returns rsp_status=2'b01 and page 0. A tag presented after it causes no comparison: chk_valid stays 0 and err_tag is unchanged.
- R5: A read of an entry whose stored parity does not match returns rsp_status=2'b10 and page 0, and sets err_parity in the same cycle as the response. A tag presented after it causes no comparison.
- R6: When a tag is presented after a successful read has been handed over, chk_valid is 1 on the next cycle and chk_ok shows whether the tag equals the read LBA. A mismatch sets err_tag.
- R7: err_parity and err_tag stay set until an err_clr pulse. They read 0 on the cycle after the pulse unless a new error arrives in the same cycle, in which case the new error wins.
- R8: While rsp_valid=1 and rsp_ready=0, req_ready is 0 and the response fields hold still.
- R9: A tag presented when no successful read is awaiting its tag is ignored: chk_valid stays 0 and err_tag is unchanged. Each successful read allows one comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = record mapping, 0 = look up |
| req_lba | input | LBA_W | Logical block address |
| req_page | input | PAGE_W | Page pointer to record (write) |
| req_data | input | DATA_W | User data to join with the LBA (write) |
| req_bad_par | input | 1 | Test hook: store the entry with inverted parity |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken this cycle |
| rsp_write | output | 1 | Response belongs to a write |
| rsp_lba | output | LBA_W | LBA of the request |
| rsp_page | output | PAGE_W | Page pointer (0 unless status is OK) |
| rsp_status | output | 2 | 00 ok, 01 unmapped, 10 parity error |
| rsp_word | output | LBA_W+DATA_W | Storage word {lba, data} for writes, 0 for reads |
| tag_valid | input | 1 | LBA tag read back from the page is present |
| tag_lba | input | LBA_W | LBA tag read back from the page |
| chk_valid | output | 1 | Tag comparison result present |
| chk_ok | output | 1 | Tag matched the requested LBA |
| err_clr | input | 1 | Clears both sticky error flags |
| err_parity | output | 1 | Sticky: a table entry failed its parity check |
| err_tag | output | 1 | Sticky: a read-back tag did not match |

## Verification
The assertions take for granted that the requester honours the handshake: request fields do not change while req_valid waits for req_ready. They also take for granted that a tag is presented only after the read response it belongs to has been handed over. The stimulus drives requests on falling edges and keeps them steady until the acceptance is seen. Tags are sent only in the cycle after a response is taken. Parity faults come only from the req_bad_par hook, never from forced internal state, and err_clr is a single-cycle pulse.

// File: rtl/l2p_pkg.sv
package l2p_pkg;
    localparam int L2P_LBA_W  = 10;
    localparam int L2P_PAGE_W = 16;
    localparam int L2P_DATA_W = 32;

    typedef enum logic [1:0] {
        ST_OK       = 2'b00,
        ST_UNMAPPED = 2'b01,
        ST_PARITY   = 2'b10
    } lk_status_e;
endpackage

// File: rtl/l2p_table.sv
module l2p_table #(
    parameter int LBA_W  = 10,
    parameter int PAGE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LBA_W-1:0]  wr_lba,
    input  logic [PAGE_W-1:0] wr_page,
    input  logic              wr_bad_par,
    input  logic [LBA_W-1:0]  rd_lba,
    output logic [PAGE_W-1:0] rd_page,
    output logic              rd_mapped,
    output logic              rd_par_err
);
    localparam int DEPTH = 1 << LBA_W;

    typedef struct packed {
        logic              par;
        logic              mapped;
        logic [PAGE_W-1:0] page;
    } entry_t;

    entry_t mem_q [DEPTH];
    entry_t wr_entry_d;
    entry_t rd_entry;

    // Even parity over mapped flag and pointer; the hook inverts it.
    always_comb begin
        wr_entry_d.mapped = 1'b1;
        wr_entry_d.page   = wr_page;
        wr_entry_d.par    = (^{1'b1, wr_page}) ^ wr_bad_par;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (wr_en) begin
            mem_q[wr_lba] <= wr_entry_d;
        end
    end

    always_comb begin
        rd_entry   = mem_q[rd_lba];
        rd_page    = rd_entry.page;
        rd_mapped  = rd_entry.mapped;
        rd_par_err = ^rd_entry;
    end

    // R5: an unmapped entry left from reset never reports a parity fault
    p_reset_entry_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_entry.mapped && rd_entry.page == '0 && !rd_entry.par) |-> !rd_par_err);
endmodule

// File: rtl/l2p_resp.sv
module l2p_resp
    import l2p_pkg::*;
#(
    parameter int LBA_W  = 10,
    parameter int PAGE_W = 16,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [LBA_W-1:0]        req_lba,
    input  logic [PAGE_W-1:0]       req_page,
    input  logic [DATA_W-1:0]       req_data,
    output logic                    req_ready,
    output logic                    accept,
    input  logic [PAGE_W-1:0]       tbl_page,
    input  logic                    tbl_mapped,
    input  logic                    tbl_par_err,
    input  logic                    rsp_ready,
    output logic                    rsp_valid,
    output logic                    rsp_write,
    output logic [LBA_W-1:0]        rsp_lba,
    output logic [PAGE_W-1:0]       rsp_page,
    output lk_status_e              rsp_status,
    output logic [LBA_W+DATA_W-1:0] rsp_word,
    output logic                    par_ev,
    output logic                    rd_done,
    output logic                    rd_ok
);
    localparam int WORD_W = LBA_W + DATA_W;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [LBA_W-1:0]  lba;
        logic [PAGE_W-1:0] page;
        lk_status_e        status;
        logic [WORD_W-1:0] word;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    always_comb begin
        req_ready = !rsp_q.valid || rsp_ready;
        accept    = req_valid && req_ready;
        par_ev    = accept && !req_write && tbl_par_err;
        rd_done   = rsp_q.valid && rsp_ready && !rsp_q.write;
        rd_ok     = rd_done && (rsp_q.status == ST_OK);

        rsp_d = rsp_q;
        if (accept) begin
            rsp_d.valid = 1'b1;
            rsp_d.write = req_write;
            rsp_d.lba   = req_lba;
            if (req_write) begin
                rsp_d.page   = req_page;
                rsp_d.status = ST_OK;
                rsp_d.word   = {req_lba, req_data};
            end else begin
                rsp_d.word = '0;
                if (tbl_par_err) begin
                    rsp_d.page   = '0;
                    rsp_d.status = ST_PARITY;
                end else if (!tbl_mapped) begin
                    rsp_d.page   = '0;
                    rsp_d.status = ST_UNMAPPED;
                end else begin
                    rsp_d.page   = tbl_page;
                    rsp_d.status = ST_OK;
                end
            end
        end else if (rsp_ready) begin
            rsp_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '{valid: 1'b0, write: 1'b0, lba: '0, page: '0,
                       status: ST_OK, word: '0};
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid  = rsp_q.valid;
    assign rsp_write  = rsp_q.write;
    assign rsp_lba    = rsp_q.lba;
    assign rsp_page   = rsp_q.page;
    assign rsp_status = rsp_q.status;
    assign rsp_word   = rsp_q.word;

    p_hold_stalled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_lba) &&
                                       $stable(rsp_page) && $stable(rsp_status) &&
                                       $stable(rsp_word)));
    p_write_status_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_write) |-> (rsp_status == ST_OK));
    p_bad_read_page_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_write && rsp_status != ST_OK) |-> (rsp_page == '0));
    p_accept_gives_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_valid);
endmodule

// File: rtl/l2p_tag_check.sv
module l2p_tag_check #(
    parameter int LBA_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_done,
    input  logic             rd_ok,
    input  logic [LBA_W-1:0] rd_lba,
    input  logic             tag_valid,
    input  logic [LBA_W-1:0] tag_lba,
    input  logic             par_ev,
    input  logic             err_clr,
    output logic             chk_valid,
    output logic             chk_ok,
    output logic             err_parity,
    output logic             err_tag
);
    typedef struct packed {
        logic             armed;
        logic [LBA_W-1:0] lba;
        logic             chk_valid;
        logic             chk_ok;
        logic             err_par;
        logic             err_tag;
    } tag_st_t;

    tag_st_t st_d, st_q;
    logic    mismatch;

    always_comb begin
        st_d      = st_q;
        mismatch  = 1'b0;
        st_d.chk_valid = 1'b0;
        st_d.chk_ok    = 1'b0;
        if (tag_valid && st_q.armed) begin
            mismatch       = (tag_lba != st_q.lba);
            st_d.chk_valid = 1'b1;
            st_d.chk_ok    = !mismatch;
            st_d.armed     = 1'b0;
        end
        // A finished read re-arms only if its lookup succeeded.
        if (rd_done) begin
            st_d.armed = rd_ok;
            st_d.lba   = rd_lba;
        end
        // Clear first, then a new event in the same cycle wins.
        st_d.err_par = (st_q.err_par & ~err_clr) | par_ev;
        st_d.err_tag = (st_q.err_tag & ~err_clr) | mismatch;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chk_valid  = st_q.chk_valid;
    assign chk_ok     = st_q.chk_ok;
    assign err_parity = st_q.err_par;
    assign err_tag    = st_q.err_tag;

    p_par_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_parity && !err_clr) |=> err_parity);
    p_tag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_tag && !err_clr) |=> err_tag);
    p_unarmed_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_valid && !st_q.armed) |=> !chk_valid);
    p_fail_sets_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && !chk_ok) |-> err_tag);
endmodule

// File: rtl/l2p_tag_map.sv
module l2p_tag_map
    import l2p_pkg::*;
#(
    parameter int LBA_W  = L2P_LBA_W,
    parameter int PAGE_W = L2P_PAGE_W,
    parameter int DATA_W = L2P_DATA_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic [LBA_W-1:0]        req_lba,
    input  logic [PAGE_W-1:0]       req_page,
    input  logic [DATA_W-1:0]       req_data,
    input  logic                    req_bad_par,
    output logic                    rsp_valid,
    input  logic                    rsp_ready,
    output logic                    rsp_write,
    output logic [LBA_W-1:0]        rsp_lba,
    output logic [PAGE_W-1:0]       rsp_page,
    output logic [1:0]              rsp_status,
    output logic [LBA_W+DATA_W-1:0] rsp_word,
    input  logic                    tag_valid,
    input  logic [LBA_W-1:0]        tag_lba,
    output logic                    chk_valid,
    output logic                    chk_ok,
    input  logic                    err_clr,
    output logic                    err_parity,
    output logic                    err_tag
);
    logic              accept;
    logic [PAGE_W-1:0] tbl_page;
    logic              tbl_mapped;
    logic              tbl_par_err;
    logic              par_ev;
    logic              rd_done;
    logic              rd_ok;
    lk_status_e        status_e;

    l2p_table #(.LBA_W(LBA_W), .PAGE_W(PAGE_W)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (accept && req_write),
        .wr_lba     (req_lba),
        .wr_page    (req_page),
        .wr_bad_par (req_bad_par),
        .rd_lba     (req_lba),
        .rd_page    (tbl_page),
        .rd_mapped  (tbl_mapped),
        .rd_par_err (tbl_par_err)
    );

    l2p_resp #(.LBA_W(LBA_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_resp (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_lba     (req_lba),
        .req_page    (req_page),
        .req_data    (req_data),
        .req_ready   (req_ready),
        .accept      (accept),
        .tbl_page    (tbl_page),
        .tbl_mapped  (tbl_mapped),
        .tbl_par_err (tbl_par_err),
        .rsp_ready   (rsp_ready),
        .rsp_valid   (rsp_valid),
        .rsp_write   (rsp_write),
        .rsp_lba     (rsp_lba),
        .rsp_page    (rsp_page),
        .rsp_status  (status_e),
        .rsp_word    (rsp_word),
        .par_ev      (par_ev),
        .rd_done     (rd_done),
        .rd_ok       (rd_ok)
    );

    assign rsp_status = status_e;

    l2p_tag_check #(.LBA_W(LBA_W)) u_tag (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_done    (rd_done),
        .rd_ok      (rd_ok),
        .rd_lba     (rsp_lba),
        .tag_valid  (tag_valid),
        .tag_lba    (tag_lba),
        .par_ev     (par_ev),
        .err_clr    (err_clr),
        .chk_valid  (chk_valid),
        .chk_ok     (chk_ok),
        .err_parity (err_parity),
        .err_tag    (err_tag)
    );

    // R5: a parity-failed read raises the sticky flag with its response
    p_par_flag_with_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_write && rsp_status == 2'b10 && $rose(rsp_valid)) |-> err_parity);
endmodule

// File: tb/test_l2p_tag_map.sv
module test_l2p_tag_map;
    localparam int LW = 10;
    localparam int PW = 16;
    localparam int DW = 32;

    typedef struct packed {
        logic          write;
        logic [LW-1:0] lba;
        logic [PW-1:0] page;
        logic [1:0]    status;
        logic [LW+DW-1:0] word;
    } exp_t;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_write = 0, req_bad_par = 0;
    logic [LW-1:0] req_lba = '0;
    logic [PW-1:0] req_page = '0;
    logic [DW-1:0] req_data = '0;
    logic rsp_ready = 1, tag_valid = 0, err_clr = 0;
    logic [LW-1:0] tag_lba = '0;
    logic req_ready, rsp_valid, rsp_write, chk_valid, chk_ok, err_parity, err_tag;
    logic [LW-1:0] rsp_lba;
    logic [PW-1:0] rsp_page;
    logic [1:0] rsp_status;
    logic [LW+DW-1:0] rsp_word;

    int checks = 0, errors = 0;
    bit done = 0;
    exp_t q[$];
    logic [PW-1:0] m_page [1<<LW];
    logic m_map [1<<LW];
    logic m_bad [1<<LW];

    always #5 clk = ~clk;

    l2p_tag_map i_l2p_tag_map (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pop one expected item per handed-over response.
    always begin
        @(negedge clk);
        #1;
        if (rst_n && rsp_valid && rsp_ready) begin
            if (q.size() == 0) begin
                chk("R8 unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(e.write ? "R2 rsp_write" : "R3 rsp_write", rsp_write, e.write);
                chk("R2 rsp_lba", rsp_lba, e.lba);
                chk(e.write ? "R2 page" : "R3 R4 R5 page", rsp_page, e.page);
                chk(e.write ? "R2 status" : "R3 R4 R5 status", rsp_status, e.status);
                chk("R2 rsp_word", rsp_word, e.word);
            end
        end
    end

    task automatic issue(input logic wr, input int lba, input int page,
                         input int data, input logic bad);
        exp_t e;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_lba = lba[LW-1:0];
        req_page = page[PW-1:0]; req_data = data; req_bad_par = bad;
        e.write = wr; e.lba = lba[LW-1:0];
        if (wr) begin
            e.page = page[PW-1:0]; e.status = 2'b00; e.word = {lba[LW-1:0], data};
            m_page[lba] = page[PW-1:0]; m_map[lba] = 1; m_bad[lba] = bad;
        end else begin
            e.word = '0;
            if (m_map[lba] && m_bad[lba]) begin e.page = '0; e.status = 2'b10; end
            else if (!m_map[lba]) begin e.page = '0; e.status = 2'b01; end
            else begin e.page = m_page[lba]; e.status = 2'b00; end
        end
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        q.push_back(e);
        @(negedge clk);
        req_valid = 0; req_bad_par = 0;
    endtask

    task automatic send_tag(input int lba);
        @(negedge clk);
        tag_valid = 1; tag_lba = lba[LW-1:0];
        @(negedge clk);
        tag_valid = 0;
        #2;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        err_clr = 1;
        @(negedge clk);
        err_clr = 0;
        #2;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < (1<<LW); i++) begin m_map[i] = 0; m_bad[i] = 0; m_page[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        #2;
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 req_ready", req_ready, 1);
        chk("R1 err_parity", err_parity, 0);
        chk("R1 err_tag", err_tag, 0);
        chk("R1 chk_valid", chk_valid, 0);

        // R1 R4: fresh table is unmapped, tag after it ignored
        issue(0, 5, 0, 0, 0);
        send_tag(5);
        chk("R4 no compare chk_valid", chk_valid, 0);
        chk("R4 err_tag", err_tag, 0);

        // R2 writes including boundary LBAs
        issue(1, 5, 16'h1234, 32'hA5A5_0001, 0);
        issue(1, 1023, 16'hBEEF, 32'hFFFF_FFFF, 0);
        issue(1, 0, 16'h0007, 32'h0, 0);

        // R3 R6 matching tag
        issue(0, 5, 0, 0, 0);
        send_tag(5);
        chk("R6 chk_valid", chk_valid, 1);
        chk("R6 chk_ok", chk_ok, 1);
        chk("R6 err_tag clean", err_tag, 0);

        // R9 second tag for the same read is ignored
        send_tag(6);
        chk("R9 chk_valid", chk_valid, 0);
        chk("R9 err_tag", err_tag, 0);

        // R6 mismatch
        issue(0, 1023, 0, 0, 0);
        send_tag(3);
        chk("R6 mismatch chk_valid", chk_valid, 1);
        chk("R6 mismatch chk_ok", chk_ok, 0);
        chk("R6 err_tag set", err_tag, 1);
        issue(0, 0, 0, 0, 0);
        repeat (4) @(negedge clk);
        #2;
        chk("R7 err_tag held", err_tag, 1);
        pulse_clr();
        chk("R7 err_tag cleared", err_tag, 0);

        // R3 overwrite returns latest page
        issue(1, 5, 16'h0042, 32'h1111_2222, 0);
        issue(0, 5, 0, 0, 0);

        // R5 corrupted entry
        issue(1, 9, 16'h00F0, 32'h3, 1);
        issue(0, 9, 0, 0, 0);
        #1;
        chk("R5 err_parity", err_parity, 1);
        send_tag(9);
        chk("R5 no compare", chk_valid, 0);
        chk("R5 err_tag untouched", err_tag, 0);
        issue(1, 9, 16'h00F1, 32'h4, 0);
        issue(0, 9, 0, 0, 0);
        chk("R7 err_parity held", err_parity, 1);
        pulse_clr();
        chk("R7 err_parity cleared", err_parity, 0);

        // R7 clear and new error together: error wins
        issue(1, 11, 16'h0011, 32'h5, 1);
        @(negedge clk);
        err_clr = 1; req_valid = 1; req_write = 0; req_lba = 11;
        q.push_back('{write: 1'b0, lba: 10'd11, page: 16'h0, status: 2'b10, word: '0});
        @(negedge clk);
        err_clr = 0; req_valid = 0;
        #2;
        chk("R7 event beats clear", err_parity, 1);
        pulse_clr();

        // R8 back-pressure
        @(negedge clk);
        rsp_ready = 0;
        issue(0, 0, 0, 0, 0);
        #1;
        chk("R8 req_ready low", req_ready, 0);
        chk("R8 rsp_valid", rsp_valid, 1);
        repeat (3) @(negedge clk);
        #1;
        chk("R8 held page", rsp_page, 16'h0007);
        chk("R8 held status", rsp_status, 2'b00);
        chk("R8 req_ready still low", req_ready, 0);
        @(negedge clk);
        rsp_ready = 1;
        @(negedge clk);

        // Mixed traffic through the scoreboard
        lfsr = 16'hACE1;
        for (int n = 0; n < 60; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            issue(lfsr[0], {6'd0, lfsr[4:1]} + 32, lfsr, {lfsr, lfsr}, 0);
        end

        repeat (4) @(negedge clk);
        chk("R8 scoreboard drained", q.size(), 0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule